// File: doc/BRIEF.md
# Priority-Ranked Pad Function Selector

This block decides which internal signal owns each of a small group of chip pads. Every pad has up to four ranked candidate signals plus one fallback signal. A candidate is enabled by a Boolean expression over bits of five software-written control words and one strap word. An expression is an AND of single-bit or field comparisons, and a candidate may have several expressions that are ORed. The strap word is captured from input pins once, when reset is released. On every pad the lowest-numbered candidate whose expression is true wins. When no candidate is true, the fallback signal wins.

Software reaches the control words through a small request/response port. Requests carry a valid/ready handshake. Read data returns on a response channel that also has valid/ready. While a response waits for the consumer to take it, no new request is accepted. The winning level on each pad is decoded combinationally from the stored words. The decode steers the pad input to the winning peripheral and steers the winning peripheral's output to the pad. Every peripheral that does not win sees a fixed idle level. A one-hot select vector per pad is also output so that the choice can be observed.

Top module: `pmx_top`

## Requirements
- R1: After reset, all five control words read 0, `rsp_valid` is 0, and the captured strap word is 0 until the strap pins are sampled.
- R2: Word addresses are 0 to 4 for control words c0 to c4 and 5 for the strap word s. Select bit l of a pad means level l is active, and bit 4 means the fallback is active. The pad rules are as follows. Pad 0: level 0 when c0[0]=1. Pad 1: level 0 when c2[3]=1, c0[15]=1 and c1[31]=0; level 1 when c2[3]=1, c0[15]=1 and c1[31]=1. Pad 2: level 0 when c0[12]=1 or s[14]=1. Pad 3: level 0 when c1[5:4]!=0 and c3[17]=1; level 1 when c3[17]=1. Pad 4: level 0 when c1[5:4]=3 and c3[22]=1; level 1 when c3[22]=1. Pad 5: level 0 when c4[0]=1; level 1 when s[6]=0. Pad 6: level 0 when c0[25]=1; level 1 when c4[12]=1 or s[19]=0.
- R3: On each pad, exactly one select bit is set. The lowest-numbered true level wins, and the fallback bit is set only when no level is true.
- R4: A comparison can require a bit to be 0. On pad 1, the value of c1[31] alone chooses between level 0 and level 1 once c2[3] and c0[15] are both 1. When either of those two bits is 0, the pad uses the fallback.
- R5: ORed alternatives work. On pad 2, either c0[12]=1 or strap bit 14 set selects level 0. On pad 6, level 1 is active while c4[12]=0 as long as strap bit 19 is 0.
- R6: Two-bit field comparisons work. The field c1[5:4] uses the encoding 00 = off, 01 = 18-bit, 10 = 24-bit, 11 = 30-bit. Any nonzero value enables pad 3 level 0. Only the value 3 enables pad 4 level 0. In both cases the field test only counts together with the pad's own enable bit.
- R7: The strap word is taken from `strap_pins` at the first clock edge after reset release. It then holds until the next reset. Writes to address 5 are ignored, and a read of address 5 returns the captured word.
- R8: A request is accepted when `req_valid` and `req_ready` are both 1. An accepted read presents its data on `rsp_data` with `rsp_valid`=1 in the next cycle. While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0, and `rsp_valid` and `rsp_data` hold.
- R9: A control-word write changes the pad selects in the cycle after the write is accepted, and not before.
- R10: `pad_out[p]` equals `periph_tx[p*5+l]` for the active level l. `periph_rx[p*5+l]` equals `pad_in[p]` for the active level and equals the idle level (0 by default) for every other level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pins | input | 32 | Strap levels, captured after reset release |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 32 | Read response data |
| pad_in | input | 7 | Level received on each pad |
| pad_out | output | 7 | Level driven on each pad |
| periph_tx | input | 35 | Per pad and level, the value the peripheral wants driven (index p*5+l) |
| periph_rx | output | 35 | Per pad and level, the value delivered to the peripheral (index p*5+l) |
| pad_sel | output | 35 | One-hot active level per pad (index p*5+l, bit 4 = fallback) |

## Verification
The assertions check the following on every cycle: each select vector is one-hot, the pad and peripheral steering follow the select, a response is held while it is back-pressured, the strap word stays stable after capture, and a write to pad 0's enable bit takes effect one cycle later. The decode rules themselves can only be shown by scenarios. These cover the AND with a compare-to-0 term, the ORed strap alternatives, the exact-versus-nonzero field tests and priority masking. The scenarios also show strap capture across two resets with different pin values and that strap writes are ignored. They are exercised by random control words checked against a bench model, plus directed cases.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 3;
  localparam int NCTL      = 5;
  localparam int STRAP_IDX = NCTL;
  localparam int NPAD      = 7;
  localparam int LVL_N     = 5;
  localparam int NRANK     = LVL_N - 1;
  localparam int FALLBACK  = LVL_N - 1;

  typedef logic [DATA_W-1:0]           word_t;
  typedef logic [NCTL-1:0][DATA_W-1:0] ctl_bank_t;
  typedef logic [LVL_N-1:0]            lvl_vec_t;
  typedef logic [NRANK-1:0]            rank_vec_t;
endpackage

// File: rtl/pmx_regs.sv
module pmx_regs
  import pmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  word_t             strap_pins,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  word_t             req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output word_t             rsp_data,
  output ctl_bank_t         ctl,
  output word_t             strap_q,
  output logic              strap_done
);
  logic  accept;
  word_t rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (req_addr < ADDR_W'(NCTL))
      rd_mux = ctl[req_addr];
    else if (req_addr == ADDR_W'(STRAP_IDX))
      rd_mux = strap_q;
    else
      rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl        <= '0;
      strap_q    <= '0;
      strap_done <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      if (!strap_done) begin
        strap_q    <= strap_pins;
        strap_done <= 1'b1;
      end
      if (accept && req_write && (req_addr < ADDR_W'(NCTL)))
        ctl[req_addr] <= req_wdata;
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_mux;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pmx_rank_eval.sv
module pmx_rank_eval
  import pmx_pkg::*;
(
  input  ctl_bank_t                  ctl,
  input  word_t                      strap,
  output logic [NPAD-1:0][NRANK-1:0] hit
);
  logic [1:0] vid_mode;
  logic       unused_bits;

  assign vid_mode    = ctl[1][5:4];
  assign unused_bits = ^{ctl, strap};

  always_comb begin
    hit = '0;
    // pad 0: single peripheral
    hit[0][0] = ctl[0][0];
    // pad 1: shared enables, bit 31 of c1 picks the rank
    hit[1][0] = ctl[2][3] & ctl[0][15] & ~ctl[1][31];
    hit[1][1] = ctl[2][3] & ctl[0][15] &  ctl[1][31];
    // pad 2: software bit or strap
    hit[2][0] = ctl[0][12] | strap[14];
    // pad 3: any video mode plus own enable
    hit[3][0] = (vid_mode != 2'b00) & ctl[3][17];
    hit[3][1] = ctl[3][17];
    // pad 4: only the widest video mode plus own enable
    hit[4][0] = (vid_mode == 2'b11) & ctl[3][22];
    hit[4][1] = ctl[3][22];
    // pad 5: fallback is not a general-purpose signal
    hit[5][0] = ctl[4][0];
    hit[5][1] = ~strap[6];
    // pad 6: low rank enabled by software or by cleared strap
    hit[6][0] = ctl[0][25];
    hit[6][1] = ctl[4][12] | ~strap[19];
  end
endmodule

// File: rtl/pmx_prio_pick.sv
module pmx_prio_pick
  import pmx_pkg::*;
(
  input  logic [NPAD-1:0][NRANK-1:0] hit,
  output logic [NPAD-1:0][LVL_N-1:0] sel
);
  function automatic lvl_vec_t pick(rank_vec_t h);
    lvl_vec_t s;
    s = '0;
    s[FALLBACK] = 1'b1;
    for (int l = NRANK - 1; l >= 0; l--)
      if (h[l]) s = lvl_vec_t'(1) << l;
    return s;
  endfunction

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    assign sel[p] = pick(hit[p]);
  end
endmodule

// File: rtl/pmx_steer.sv
module pmx_steer
  import pmx_pkg::*;
#(
  parameter logic RX_IDLE = 1'b0
) (
  input  logic [NPAD-1:0][LVL_N-1:0] sel,
  input  logic [NPAD-1:0]            pad_in,
  output logic [NPAD-1:0]            pad_out,
  input  logic [NPAD-1:0][LVL_N-1:0] tx,
  output logic [NPAD-1:0][LVL_N-1:0] rx
);
  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    assign pad_out[p] = |(sel[p] & tx[p]);
    for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
      assign rx[p][l] = sel[p][l] ? pad_in[p] : RX_IDLE;
    end
  end
endmodule

// File: rtl/pmx_top.sv
module pmx_top
  import pmx_pkg::*;
#(
  parameter logic RX_IDLE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       strap_pins,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DATA_W-1:0]       rsp_data,
  input  logic [NPAD-1:0]         pad_in,
  output logic [NPAD-1:0]         pad_out,
  input  logic [NPAD*LVL_N-1:0]   periph_tx,
  output logic [NPAD*LVL_N-1:0]   periph_rx,
  output logic [NPAD*LVL_N-1:0]   pad_sel
);
  ctl_bank_t                  ctl;
  word_t                      strap_q;
  logic                       strap_done;
  logic [NPAD-1:0][NRANK-1:0] hit;
  logic [NPAD-1:0][LVL_N-1:0] sel;
  logic [NPAD-1:0][LVL_N-1:0] rx;

  pmx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strap_pins(strap_pins),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ctl(ctl), .strap_q(strap_q), .strap_done(strap_done)
  );

  pmx_rank_eval u_eval (.ctl(ctl), .strap(strap_q), .hit(hit));

  pmx_prio_pick u_pick (.hit(hit), .sel(sel));

  pmx_steer #(.RX_IDLE(RX_IDLE)) u_steer (
    .sel(sel), .pad_in(pad_in), .pad_out(pad_out),
    .tx(periph_tx), .rx(rx)
  );

  assign pad_sel   = sel;
  assign periph_rx = rx;
endmodule

// File: rtl/pmx_check.sv
module pmx_check
  import pmx_pkg::*;
#(
  parameter logic RX_IDLE = 1'b0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_write,
  input logic [ADDR_W-1:0]     req_addr,
  input logic [DATA_W-1:0]     req_wdata,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [DATA_W-1:0]     rsp_data,
  input logic [NPAD-1:0]       pad_in,
  input logic [NPAD-1:0]       pad_out,
  input logic [NPAD*LVL_N-1:0] periph_tx,
  input logic [NPAD*LVL_N-1:0] periph_rx,
  input logic [NPAD*LVL_N-1:0] pad_sel,
  input logic [DATA_W-1:0]     strap_q,
  input logic                  strap_done
);
  logic wr0;
  assign wr0 = req_valid && req_ready && req_write && (req_addr == '0);

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pad_sel[p*LVL_N +: LVL_N]) == 1);
    for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
      p_pad_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pad_sel[p*LVL_N+l] |-> pad_out[p] == periph_tx[p*LVL_N+l]);
      p_rx_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pad_sel[p*LVL_N+l] |-> periph_rx[p*LVL_N+l] == pad_in[p]);
      p_rx_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_sel[p*LVL_N+l] |-> periph_rx[p*LVL_N+l] == RX_IDLE);
    end
  end

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  p_stall_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  p_strap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> strap_done && $stable(strap_q));
  p_write_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 && req_wdata[0] |=> pad_sel[0]);
  p_write_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 && !req_wdata[0] |=> pad_sel[LVL_N-1]);
endmodule

bind pmx_top pmx_check #(.RX_IDLE(RX_IDLE)) u_pmx_check (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .pad_in(pad_in), .pad_out(pad_out), .periph_tx(periph_tx),
  .periph_rx(periph_rx), .pad_sel(pad_sel),
  .strap_q(strap_q), .strap_done(strap_done)
);

// File: tb/test_pmx_top.sv
`timescale 1ns/1ps
module test_pmx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] strap_pins = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [6:0]  pad_in = '0;
  logic [6:0]  pad_out;
  logic [34:0] periph_tx = '0;
  logic [34:0] periph_rx;
  logic [34:0] pad_sel;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;
  logic [31:0] mc [5];
  logic [31:0] ms;

  always #2.5 clk = ~clk;

  pmx_top i_pmx_top (
    .clk(clk), .rst_n(rst_n), .strap_pins(strap_pins),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pad_in(pad_in), .pad_out(pad_out), .periph_tx(periph_tx),
    .periph_rx(periph_rx), .pad_sel(pad_sel)
  );

  task automatic chk(string req, string what, logic [34:0] act, logic [34:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_sel(int p);
    logic [3:0] h;
    h = '0;
    case (p)
      0: h[0] = mc[0][0];
      1: begin
        h[0] = mc[2][3] && mc[0][15] && !mc[1][31];
        h[1] = mc[2][3] && mc[0][15] &&  mc[1][31];
      end
      2: h[0] = mc[0][12] || ms[14];
      3: begin h[0] = (mc[1][5:4] != 2'b00) && mc[3][17]; h[1] = mc[3][17]; end
      4: begin h[0] = (mc[1][5:4] == 2'b11) && mc[3][22]; h[1] = mc[3][22]; end
      5: begin h[0] = mc[4][0]; h[1] = !ms[6]; end
      6: begin h[0] = mc[0][25]; h[1] = mc[4][12] || !ms[19]; end
      default: ;
    endcase
    if (h[0]) return 5'b00001;
    if (h[1]) return 5'b00010;
    return 5'b10000;
  endfunction

  task automatic check_pads(string req);
    for (int p = 0; p < 7; p++)
      chk(req, $sformatf("pad%0d select", p), 35'(pad_sel[p*5 +: 5]), 35'(exp_sel(p)));
  endtask

  task automatic check_steer();
    @(negedge clk);
    periph_tx = 35'({$urandom(), $urandom()});
    pad_in    = 7'($urandom());
    #1;
    for (int p = 0; p < 7; p++) begin
      logic [4:0] s;
      int lv;
      s  = exp_sel(p);
      lv = 4;
      for (int l = 0; l < 5; l++) if (s[l]) lv = l;
      chk("R10", $sformatf("pad%0d out", p), 35'(pad_out[p]), 35'(periph_tx[p*5+lv]));
      for (int l = 0; l < 5; l++)
        chk("R10", $sformatf("pad%0d rx%0d", p, l), 35'(periph_rx[p*5+l]),
            35'((l == lv) ? pad_in[p] : 1'b0));
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (a < 5) mc[a] = d;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "read response valid", 35'(rsp_valid), 35'(1));
    d = rsp_data;
  endtask

  task automatic do_reset(logic [31:0] sp);
    @(negedge clk);
    rst_n = 1'b0; strap_pins = sp;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "rsp_valid in reset", 35'(rsp_valid), 35'(0));
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) mc[i] = '0;
    ms = sp;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL R8 watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    void'($urandom(32'h1357));

    // Phase A: strap bits 14 and 6 set, 19 clear
    do_reset(32'h0000_4040);
    strap_pins = 32'hFFFF_FFFF;
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      chk("R1", $sformatf("c%0d after reset", a), 35'(d), 35'(0));
    end
    check_pads("R2");
    chk("R5", "pad2 level0 via strap14", 35'(pad_sel[10 +: 5]), 35'(5'b00001));
    chk("R5", "pad6 level1 via cleared strap19", 35'(pad_sel[30 +: 5]), 35'(5'b00010));
    rd(5, d);
    chk("R7", "strap captured", 35'(d), 35'(32'h0000_4040));
    wr(5, 32'h0000_0000);
    rd(5, d);
    chk("R7", "strap write ignored", 35'(d), 35'(32'h0000_4040));
    check_pads("R7");

    // R9: no effect before the edge, effect right after it
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd0; req_wdata = 32'h1;
    #1;
    chk("R9", "pad0 before edge", 35'(pad_sel[0 +: 5]), 35'(5'b10000));
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; mc[0] = 32'h1;
    chk("R9", "pad0 after edge", 35'(pad_sel[0 +: 5]), 35'(5'b00001));

    // R4: AND with a compare-to-0 term
    wr(2, 32'h8);
    chk("R4", "pad1 missing c0[15]", 35'(pad_sel[5 +: 5]), 35'(5'b10000));
    wr(0, 32'h8000);
    chk("R4", "pad1 level0 with c1[31]=0", 35'(pad_sel[5 +: 5]), 35'(5'b00001));
    wr(1, 32'h8000_0000);
    chk("R4", "pad1 level1 with c1[31]=1", 35'(pad_sel[5 +: 5]), 35'(5'b00010));
    check_pads("R3");

    // R6: field tests
    wr(3, 32'h0042_0000);
    wr(1, 32'h0000_0000);
    chk("R6", "pad3 field off", 35'(pad_sel[15 +: 5]), 35'(5'b00010));
    chk("R6", "pad4 field off", 35'(pad_sel[20 +: 5]), 35'(5'b00010));
    wr(1, 32'h0000_0010);
    chk("R6", "pad3 field 18b", 35'(pad_sel[15 +: 5]), 35'(5'b00001));
    chk("R6", "pad4 field 18b", 35'(pad_sel[20 +: 5]), 35'(5'b00010));
    wr(1, 32'h0000_0030);
    chk("R6", "pad4 field 30b", 35'(pad_sel[20 +: 5]), 35'(5'b00001));
    wr(3, 32'h0000_0000);
    chk("R6", "pad3 own enable clear", 35'(pad_sel[15 +: 5]), 35'(5'b10000));
    check_steer();

    // R8: back-pressure on the response channel
    wr(3, 32'h00C0_FFEE);
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd3;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 32'h0; req_addr = 3'd3;
    #1;
    chk("R8", "rsp valid stalled", 35'(rsp_valid), 35'(1));
    chk("R8", "req_ready low while stalled", 35'(req_ready), 35'(0));
    held = rsp_data;
    @(negedge clk);
    chk("R8", "rsp data held", 35'(rsp_data), 35'(held));
    chk("R8", "rsp data value", 35'(held), 35'(32'h00C0_FFEE));
    req_valid = 1'b0; req_write = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    chk("R8", "rsp drained", 35'(rsp_valid), 35'(0));
    rd(3, d);
    chk("R8", "stalled write not taken", 35'(d), 35'(32'h00C0_FFEE));

    // Random control words against the model
    for (int it = 0; it < 300; it++) begin
      int a;
      a = int'($urandom_range(0, 4));
      wr(a, $urandom());
      check_pads("R3");
      if (it % 10 == 0) check_steer();
      if (it % 25 == 0) begin
        rd(a, d);
        chk("R8", "random readback", 35'(d), 35'(mc[a]));
      end
    end

    // Phase B: different strap, bit 19 set, 6 and 14 clear
    do_reset(32'h0008_0000);
    strap_pins = 32'h0000_0000;
    check_pads("R1");
    chk("R2", "pad5 level1 via cleared strap6", 35'(pad_sel[25 +: 5]), 35'(5'b00010));
    chk("R5", "pad6 fallback with strap19", 35'(pad_sel[30 +: 5]), 35'(5'b10000));
    wr(4, 32'h0000_1000);
    chk("R5", "pad6 level1 via c4[12]", 35'(pad_sel[30 +: 5]), 35'(5'b00010));
    wr(4, 32'h0000_1001);
    chk("R3", "pad5 level0 masks level1", 35'(pad_sel[25 +: 5]), 35'(5'b00001));
    rd(5, d);
    chk("R7", "strap recaptured", 35'(d), 35'(32'h0008_0000));
    for (int it = 0; it < 150; it++) begin
      wr(int'($urandom_range(0, 4)), $urandom());
      check_pads("R3");
      if (it % 15 == 0) check_steer();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule